// File: doc/BRIEF.md
# Control Signal Glitch Filter

This block sits in front of a serial link framer and conditions three slow control lines: horizontal sync, vertical sync and data enable. The lines are sampled on the pixel clock. In normal operation each line may change only a limited number of times in any window of `WIN` pixel clocks. When the filter is switched on, horizontal sync and data enable must also hold a new level for several clocks before it is passed on. A change that would exceed the budget is not dropped. The output keeps its old level, and the change goes out at the first clock the budget allows, provided the input still asks for it.

A two-bit mode input selects the behaviour. The first choice is normal operation with only the rate limit. The second is normal operation with the rate limit and the pulse qualifier. The third is a legacy setting in which all three lines pass through a single register with no limits. Each line keeps its own history, so the lines never affect each other.

Top module: `ctl_glitch_filter`

## Requirements
- R1: Bit positions are fixed on both ctl_in and ctl_out: bit 0 is horizontal sync, bit 1 is vertical sync, bit 2 is data enable.
- R2: While rst_n is low, ctl_out is 3'b000. The first transition on any line after reset is passed without waiting for a window.
- R3: mode_sel decodes as follows: 2'b00 is normal with the qualifier off, 2'b01 is normal with the qualifier on, and 2'b10 and 2'b11 are both legacy.
- R4: In legacy mode, each ctl_out bit equals the ctl_in bit sampled at the previous clock edge.
- R5: In normal mode, horizontal sync and data enable each pass at most 2 output transitions in any WIN (130) consecutive clocks. The third transition comes at least WIN edges after the first.
- R6: In normal mode, vertical sync passes at most 1 output transition per WIN clocks, so every vertical sync output level lasts at least WIN clocks.
- R7: With the qualifier on, a horizontal sync or data enable level reaches the output only after 3 consecutive equal samples. With budget available, the output changes at the fourth edge after the input changes. Pulses shorter than 3 clocks never appear.
- R8: With the qualifier off and budget available, a horizontal sync or data enable change appears at the second clock edge after the input changes, whatever the pulse width.
- R9: A change held off by the budget leaves the output at its previous level. It is applied at the first edge where the budget allows it, if the input still differs from the output. Otherwise it is dropped.
- R10: The three lines are filtered independently. Activity on one line never delays or releases a change on another.
- R11: Vertical sync is never pulse-qualified. In both normal modes, an allowed vertical sync change appears at the second edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Operating mode select (see R3) |
| ctl_in | input | 3 | Raw control lines {DE, VS, HS} |
| ctl_out | output | 3 | Filtered control lines to the framer |

## Verification
The interesting collision is a held-off transition whose window expires in the same cycle that the input's pulse qualification completes. The release then depends on both the age counter and the stability counter agreeing on that edge.

The bench provokes this by toggling horizontal sync and data enable in bursts with the qualifier on, so pending changes pile up against the window. A bench-side reference tracks the times of accepted transitions and the last three input samples, and the outputs are compared with it every cycle. Directed cases pin the exact release edge of a blocked third transition and of a blocked vertical sync fall.

// File: rtl/ctlf_pkg.sv
package ctlf_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_FILT  = 2'b01,
    MODE_LEG0  = 2'b10,
    MODE_LEG1  = 2'b11
  } ctlf_mode_e;

  localparam int NCH   = 3;
  localparam int CH_HS = 0;
  localparam int CH_VS = 1;
  localparam int CH_DE = 2;

  // saturating increment used by every age and run counter
  function automatic int sat_inc(input int val, input int cap);
    return (val >= cap) ? cap : val + 1;
  endfunction

  // a window is open once the tracked age has reached its limit
  function automatic bit window_open(input int age, input int win);
    return age >= win;
  endfunction

endpackage

// File: rtl/ctlf_mode_dec.sv
module ctlf_mode_dec (
  input  logic [1:0] mode_sel,
  output logic       legacy,
  output logic       filt_on
);
  import ctlf_pkg::*;

  ctlf_mode_e mode;

  assign mode    = ctlf_mode_e'(mode_sel);
  assign legacy  = (mode == MODE_LEG0) || (mode == MODE_LEG1);
  assign filt_on = (mode == MODE_FILT);

endmodule

// File: rtl/ctlf_qualify.sv
module ctlf_qualify #(
  parameter int MIN_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic cand,
  output logic steady
);
  import ctlf_pkg::*;

  localparam int RW = $clog2(MIN_RUN + 1);

  logic          in_q;
  logic [RW-1:0] run;

  // run counts consecutive equal samples ending with in_q
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q <= 1'b0;
      run  <= RW'(MIN_RUN);
    end else begin
      in_q <= din;
      if (din != in_q) run <= RW'(1);
      else             run <= RW'(sat_inc(int'(run), MIN_RUN));
    end
  end

  assign cand   = in_q;
  assign steady = window_open(int'(run), MIN_RUN);

endmodule

// File: rtl/ctlf_budget.sv
module ctlf_budget #(
  parameter int WIN   = 130,
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  input  logic take,
  output logic room
);
  import ctlf_pkg::*;

  localparam int AW = $clog2(WIN + 1);

  // age[i] = edges since the (i+1)-th most recent accepted transition
  logic [AW-1:0] age [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      age[i] <= AW'(WIN);
        else if (reload) age[i] <= AW'(WIN);
        else if (take)   age[i] <= AW'(1);
        else             age[i] <= AW'(sat_inc(int'(age[i]), WIN));
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      age[i] <= AW'(WIN);
        else if (reload) age[i] <= AW'(WIN);
        else if (take)   age[i] <= AW'(sat_inc(int'(age[i-1]), WIN));
        else             age[i] <= AW'(sat_inc(int'(age[i]), WIN));
      end
    end
  end

  assign room = window_open(int'(age[DEPTH-1]), WIN);

endmodule

// File: rtl/ctlf_chan.sv
module ctlf_chan #(
  parameter int WIN     = 130,
  parameter int DEPTH   = 2,
  parameter int MIN_RUN = 3,
  parameter bit QUAL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic legacy,
  input  logic filt_on,
  input  logic din,
  output logic dout,
  output logic want,
  output logic accept
);
  logic cand;
  logic steady;
  logic room;

  ctlf_qualify #(.MIN_RUN(MIN_RUN)) qual_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .cand   (cand),
    .steady (steady)
  );

  ctlf_budget #(.WIN(WIN), .DEPTH(DEPTH)) budget_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .reload (legacy),
    .take   (accept),
    .room   (room)
  );

  assign want   = (cand != dout) && (!(QUAL && filt_on) || steady);
  assign accept = want && room && !legacy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dout <= 1'b0;
    else if (legacy) dout <= din;
    else if (accept) dout <= cand;
  end

endmodule

// File: rtl/ctl_glitch_filter.sv
module ctl_glitch_filter #(
  parameter int WIN       = 130,
  parameter int MIN_RUN   = 3,
  parameter int HD_BUDGET = 2,
  parameter int VS_BUDGET = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  input  logic [2:0] ctl_in,
  output logic [2:0] ctl_out
);
  import ctlf_pkg::*;

  logic           legacy;
  logic           filt_on;
  logic [NCH-1:0] chan_want;
  logic [NCH-1:0] chan_accept;

  ctlf_mode_dec mode_i (
    .mode_sel (mode_sel),
    .legacy   (legacy),
    .filt_on  (filt_on)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int CDEPTH = (c == CH_VS) ? VS_BUDGET : HD_BUDGET;
    localparam bit CQUAL  = (c != CH_VS);
    ctlf_chan #(
      .WIN     (WIN),
      .DEPTH   (CDEPTH),
      .MIN_RUN (MIN_RUN),
      .QUAL    (CQUAL)
    ) chan_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .legacy  (legacy),
      .filt_on (filt_on),
      .din     (ctl_in[c]),
      .dout    (ctl_out[c]),
      .want    (chan_want[c]),
      .accept  (chan_accept[c])
    );
  end

endmodule

// File: rtl/ctl_glitch_filter_chk.sv
module ctl_glitch_filter_chk #(
  parameter int WIN = 130
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_sel,
  input logic [2:0] ctl_in,
  input logic [2:0] ctl_out,
  input logic [2:0] want,
  input logic [2:0] accept
);
  localparam int AW = $clog2(WIN + 1);

  logic [2:0]    out_q;
  logic          leg_q;
  logic [AW-1:0] gap1 [3];
  logic [AW-1:0] gap2 [3];
  logic [2:0]    chg;

  assign chg = ctl_out ^ out_q;

  // independent gap counters: edges since the last and second-last output change
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 3'b000;
      leg_q <= 1'b0;
      for (int c = 0; c < 3; c++) begin
        gap1[c] <= AW'(WIN);
        gap2[c] <= AW'(WIN);
      end
    end else begin
      out_q <= ctl_out;
      leg_q <= mode_sel[1];
      for (int c = 0; c < 3; c++) begin
        if (leg_q) begin
          gap1[c] <= AW'(WIN);
          gap2[c] <= AW'(WIN);
        end else if (chg[c]) begin
          gap2[c] <= (int'(gap1[c]) >= WIN) ? AW'(WIN) : gap1[c] + AW'(1);
          gap1[c] <= AW'(1);
        end else begin
          if (int'(gap1[c]) < WIN) gap1[c] <= gap1[c] + AW'(1);
          if (int'(gap2[c]) < WIN) gap2[c] <= gap2[c] + AW'(1);
        end
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (ctl_out == 3'b000); // R2
  end

  AST_LEGACY_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel[1] && $past(mode_sel[1]) && $past(rst_n)) |-> (ctl_out == $past(ctl_in))); // R4

  AST_HS_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!leg_q && chg[0]) |-> (int'(gap2[0]) >= WIN)); // R5

  AST_DE_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    (!leg_q && chg[2]) |-> (int'(gap2[2]) >= WIN)); // R5

  AST_VS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (!leg_q && chg[1]) |-> (int'(gap1[1]) >= WIN)); // R6

  AST_HS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && $past(mode_sel) == 2'b01 && ctl_out[0] != $past(ctl_out[0]))
      |-> ($past(ctl_in[0], 2) == ctl_out[0] && $past(ctl_in[0], 3) == ctl_out[0]
           && $past(ctl_in[0], 4) == ctl_out[0])); // R7

  AST_DE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && $past(mode_sel) == 2'b01 && ctl_out[2] != $past(ctl_out[2]))
      |-> ($past(ctl_in[2], 2) == ctl_out[2] && $past(ctl_in[2], 3) == ctl_out[2]
           && $past(ctl_in[2], 4) == ctl_out[2])); // R7

  AST_HOLD_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel[1] && want[0] && !accept[0]) |=> $stable(ctl_out[0])); // R9

  AST_HOLD_VS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel[1] && want[1] && !accept[1]) |=> $stable(ctl_out[1])); // R9

  AST_HOLD_DE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel[1] && want[2] && !accept[2]) |=> $stable(ctl_out[2])); // R9

endmodule

bind ctl_glitch_filter ctl_glitch_filter_chk #(.WIN(WIN)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_sel (mode_sel),
  .ctl_in   (ctl_in),
  .ctl_out  (ctl_out),
  .want     (chan_want),
  .accept   (chan_accept)
);

// File: tb/ctl_glitch_filter_tb.sv
module ctl_glitch_filter_tb_top;

  localparam int WIN = 130;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] din = 3'b000;
  logic [2:0] dout;

  int    total = 0;
  int    bad = 0;
  bit    done = 1'b0;
  bit    cmp_on = 1'b0;
  string cur_tag = "R2";

  always #2 clk = ~clk;

  ctl_glitch_filter #(.WIN(WIN)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode),
    .ctl_in   (din),
    .ctl_out  (dout)
  );

  // reference: timestamps of accepted changes plus last three samples
  int       cyc;
  bit [2:0] mo;
  bit [2:0] s1, s2, s3;
  int       lastA [3];
  int       lastB [3];

  function automatic bit budget_ok(input int now, input int prior);
    return (now - prior) >= WIN;
  endfunction

  function automatic bit held3(input bit a, input bit b, input bit c);
    return (a == b) && (b == c);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; mo = 3'b000; s1 = 3'b000; s2 = 3'b000; s3 = 3'b000;
      for (int c = 0; c < 3; c++) begin lastA[c] = -1000; lastB[c] = -1000; end
    end else begin
      for (int c = 0; c < 3; c++) begin
        if (mode[1]) begin
          mo[c] = din[c];
          lastA[c] = -1000; lastB[c] = -1000;
        end else begin
          bit want;
          int prior;
          want  = (s1[c] != mo[c]) &&
                  (!(mode == 2'b01 && c != 1) || held3(s1[c], s2[c], s3[c]));
          prior = (c == 1) ? lastA[c] : lastB[c];
          if (want && budget_ok(cyc, prior)) begin
            mo[c] = s1[c];
            lastB[c] = lastA[c];
            lastA[c] = cyc;
          end
        end
      end
      s3 = s2; s2 = s1; s1 = din; cyc++;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      total++;
      if (dout !== mo) begin
        bad++;
        $display("FAIL %s: ctl_out=%b expected=%b mode=%b", cur_tag, dout, mo, mode);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_bit(input int b, input bit exp, input string tag);
    total++;
    if (dout[b] !== exp) begin
      bad++;
      $display("FAIL %s: ctl_out[%0d]=%b expected=%b", tag, b, dout[b], exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    cmp_on = 1'b0;
    rst_n = 1'b0; din = 3'b000; mode = m;
    step(1);
    total++;
    if (dout !== 3'b000) begin
      bad++;
      $display("FAIL R2: ctl_out=%b expected=000 in reset", dout);
    end
    step(1);
    rst_n = 1'b1;
    cmp_on = 1'b1;
  endtask

  task automatic rand_phase(input logic [1:0] m, input int den, input int n, input string tag);
    do_reset(m);
    cur_tag = tag;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 3; b++)
        if (($urandom % den) == 0) din[b] = ~din[b];
      step(1);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));

    // R2 R8: first change passes at once, two edges after the input
    do_reset(2'b00);
    cur_tag = "R8";
    din[0] = 1'b1;
    step(1); expect_bit(0, 1'b0, "R8");
    step(1); expect_bit(0, 1'b1, "R2");

    // R5 R9: third HS change held until 130 edges after the first
    do_reset(2'b00);
    cur_tag = "R5";
    din[0] = 1'b1;
    step(10); din[0] = 1'b0;
    step(10); din[0] = 1'b1;
    step(111); expect_bit(0, 1'b0, "R9");
    step(1);   expect_bit(0, 1'b1, "R5");

    // R6 R11: VS fall held until the window closes
    do_reset(2'b01);
    cur_tag = "R6";
    din[1] = 1'b1;
    step(2); expect_bit(1, 1'b1, "R11");
    step(3); din[1] = 1'b0;
    step(126); expect_bit(1, 1'b1, "R6");
    step(1);   expect_bit(1, 1'b0, "R6");

    // R7: DE glitch of 2 clocks dropped, pulse of 3 passes
    do_reset(2'b01);
    cur_tag = "R7";
    din[2] = 1'b1;
    step(2); din[2] = 1'b0;
    step(8); expect_bit(2, 1'b0, "R7");
    din[2] = 1'b1;
    step(3); expect_bit(2, 1'b0, "R7");
    din[2] = 1'b0;
    step(1); expect_bit(2, 1'b1, "R7");
    step(2); expect_bit(2, 1'b1, "R7");
    step(1); expect_bit(2, 1'b0, "R7");

    // R9: held change dropped when the input returns before release
    do_reset(2'b00);
    cur_tag = "R9";
    din[0] = 1'b1; step(5); din[0] = 1'b0; step(5); din[0] = 1'b1;
    step(20); din[0] = 1'b0;
    step(120); expect_bit(0, 1'b0, "R9");

    // R10: HS saturated window does not block DE
    do_reset(2'b00);
    cur_tag = "R10";
    din[0] = 1'b1; step(3); din[0] = 1'b0; step(3); din[0] = 1'b1;
    din[2] = 1'b1;
    step(2); expect_bit(2, 1'b1, "R10");
    expect_bit(0, 1'b0, "R10");

    // R1 R4: legacy echo with bit positions intact
    do_reset(2'b10);
    cur_tag = "R4";
    din = 3'b101;
    step(1); expect_bit(0, 1'b1, "R1");
    expect_bit(1, 1'b0, "R1");
    expect_bit(2, 1'b1, "R4");

    rand_phase(2'b00, 20, 3000, "R5");
    rand_phase(2'b01, 3, 3000, "R7");
    rand_phase(2'b01, 40, 3000, "R9");
    rand_phase(2'b10, 2, 2000, "R4");
    rand_phase(2'b11, 4, 2000, "R3");
    rand_phase(2'b00, 90, 3000, "R6");
    rand_phase(2'b00, 6, 3000, "R10");

    cmp_on = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule